// File: doc/BRIEF.md
# Multi-Output Clock Divider and Reference Select

This block is the digital division and steering logic behind a multi-output network clock generator. It runs on the high-rate oscillator clock (nominally 625 MHz). It decodes three-level configuration pins into divide ratios, reference choices and a bypass mode. It produces the output clock levels for one single-output divider bank and one seven-output divider bank. The first bank feeds differential lane 0. The second bank feeds differential lanes 1 to 6 and one single-ended lane.

Each three-level pin reaches the logic as a 2-bit code: 00 is low, 01 is high, and 10 is open (11 is read as open). The bank dividers generate divide-by-5, divide-by-4 and divide-by-2, and the divide-by-5 output keeps a 50% duty cycle by combining a rising-edge phase with a falling-edge phase. A divide-by-25 feedback path marks the comparison instants for a 25 MHz reference.

In bypass, an externally supplied reference level is steered straight to every output and the divider state is held. One group of differential lanes can be switched off. While switched off, those lanes read low and a high-impedance indication is raised for the pad drivers.

Top module: `clk_fanout_div`

## Requirements
- R1: The bank select codes map to divide ratios as follows: 00 selects divide-by-5, 01 selects divide-by-4, and 10 or 11 selects divide-by-2. The output period is the ratio in `clk` cycles.
- R2: At divide-by-5, an output is high for exactly five half-cycles of `clk` in each ten, from the middle of the first cycle of its period to the end of the third. At an even ratio N, it is high for the first N/2 cycles.
- R3: `sel_a` affects only `q_diff[0]`. `sel_b` affects `q_diff[6:1]` and `q_se`.
- R4: A change of a bank select takes effect only after the bank's current output period ends, so no high or low phase is ever cut short.
- R5: Outputs are driven low during reset. After reset is released, or after bypass is left, each bank stays low for its first full output period.
- R6: The `ref_mode` codes decode as follows. Code 01 selects the crystal reference (`xtal_sel`=1, `vco_en`=1). Code 10 or 11 selects the external input (`xtal_sel`=0, `vco_en`=1). Code 00 selects bypass (`vco_en`=0).
- R7: In bypass, `q_se` and every enabled `q_diff` lane equal `byp_ref` in the same cycle, and `fb_tick` stays low.
- R8: With `oe` low, `q_diff[6:4]` read 0 and `grp_hiz` is 1, while the other lanes are unchanged. With `oe` high, `grp_hiz` is 0.
- R9: While `vco_en` is 1 and bank B runs at divide-by-2, `se_unsup` is 1 and `q_se` is held low.
- R10: While `vco_en` is 1, `fb_tick` pulses for one cycle every 25 cycles. The first pulse comes in the 25th cycle after reset or bypass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that runs the dividers |
| rst | input | 1 | Synchronous active-high reset |
| ref_mode | input | 2 | Three-level reference/bypass code |
| sel_a | input | 2 | Three-level ratio code for bank A |
| sel_b | input | 2 | Three-level ratio code for bank B |
| oe | input | 1 | Enable for lanes 4 to 6 (1 = driving) |
| byp_ref | input | 1 | External reference level steered out in bypass |
| q_diff | output | 7 | Differential lane clock levels |
| q_se | output | 1 | Single-ended lane clock level |
| grp_hiz | output | 1 | High-impedance request for lanes 4 to 6 |
| se_unsup | output | 1 | Single-ended lane rate unsupported |
| xtal_sel | output | 1 | Loop references the crystal |
| vco_en | output | 1 | Oscillator path enabled (not bypass) |
| fb_tick | output | 1 | Feedback divide-by-25 pulse |

## Verification
The two banks are run with all four select codes, both together and apart. Comparing lanes 0 and 1 separates A from B and shows that the two open codes behave alike. Selects are changed in the middle of a period and in quick succession, which distinguishes deferred ratio changes from immediate ones that would shorten a phase. Outputs are sampled once in each half of every clock cycle, so a divide-by-5 built only on rising edges is caught, as is one whose duty or phase is offset. The enable, the three reference codes and bypass with a toggling reference are each tried, and a return from bypass checks the restart with one silent period.

// File: rtl/fo_div_pkg.sv
`timescale 1ns/1ps
package fo_div_pkg;

    localparam int DIV_LO_RATIO   = 5;
    localparam int DIV_HI_RATIO   = 4;
    localparam int DIV_OPEN_RATIO = 2;
    localparam int DIV_MAX        = 5;
    localparam int DIV_W          = $clog2(DIV_MAX + 1);
    localparam int FB_RATIO       = 25;
    localparam int SE_MIN_RATIO   = 4;

    typedef enum logic [1:0] {
        LVL_LOW      = 2'b00,
        LVL_HIGH     = 2'b01,
        LVL_OPEN     = 2'b10,
        LVL_OPEN_ALT = 2'b11
    } lvl_code_e;

    typedef enum logic [1:0] {
        SRC_BYPASS = 2'b00,
        SRC_XTAL   = 2'b01,
        SRC_EXTIN  = 2'b10
    } ref_src_e;

    typedef logic [DIV_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t cnt;
        ratio_t ratio;
        logic   started;
    } div_state_t;

    function automatic ratio_t lvl_to_ratio(input logic [1:0] code);
        case (lvl_code_e'(code))
            LVL_LOW:  return ratio_t'(DIV_LO_RATIO);
            LVL_HIGH: return ratio_t'(DIV_HI_RATIO);
            default:  return ratio_t'(DIV_OPEN_RATIO);
        endcase
    endfunction

    function automatic ref_src_e lvl_to_src(input logic [1:0] code);
        case (lvl_code_e'(code))
            LVL_LOW:  return SRC_BYPASS;
            LVL_HIGH: return SRC_XTAL;
            default:  return SRC_EXTIN;
        endcase
    endfunction

    function automatic ratio_t half_of(input ratio_t r);
        return ratio_t'((int'(r) + 1) / 2);
    endfunction

endpackage

// File: rtl/fo_div_bank.sv
`timescale 1ns/1ps
module fo_div_bank
    import fo_div_pkg::*;
#(
    parameter bit FLAG_FAST  = 1'b0,
    parameter int FAST_BELOW = SE_MIN_RATIO
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic [1:0] sel,
    output logic       div_out,
    output logic       too_fast
);

    localparam bit ANY_ODD = ((DIV_LO_RATIO % 2) != 0) ||
                             ((DIV_HI_RATIO % 2) != 0) ||
                             ((DIV_OPEN_RATIO % 2) != 0);

    div_state_t st;
    logic       pos_phase;
    logic       at_wrap;

    assign at_wrap = (st.cnt == st.ratio - ratio_t'(1));

    // The ratio is reloaded only at the period boundary, so no phase is cut short.
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            st <= '{cnt: '0, ratio: lvl_to_ratio(sel), started: 1'b0};
        end else if (at_wrap) begin
            st <= '{cnt: '0, ratio: lvl_to_ratio(sel), started: 1'b1};
        end else begin
            st.cnt <= st.cnt + ratio_t'(1);
        end
    end

    assign pos_phase = st.started && (st.cnt < half_of(st.ratio));

    generate
        if (ANY_ODD) begin : g_odd
            logic neg_phase;
            // A copy of the phase, delayed half a cycle, trims an odd ratio to 50% duty.
            always_ff @(negedge clk) begin
                if (rst || hold) begin
                    neg_phase <= 1'b0;
                end else begin
                    neg_phase <= pos_phase;
                end
            end
            assign div_out = st.ratio[0] ? (pos_phase & neg_phase) : pos_phase;
        end else begin : g_even
            assign div_out = pos_phase;
        end

        if (FLAG_FAST) begin : g_flag
            assign too_fast = (st.ratio < ratio_t'(FAST_BELOW));
        end else begin : g_noflag
            assign too_fast = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fo_fb_div.sv
`timescale 1ns/1ps
module fo_fb_div #(
    parameter int RATIO = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);

    localparam int W = $clog2(RATIO);

    logic [W-1:0] cnt;
    logic         last;

    assign last = (cnt == W'(RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign tick = !hold && last;

endmodule

// File: rtl/fo_out_stage.sv
`timescale 1ns/1ps
module fo_out_stage #(
    parameter int N_DIFF  = 7,
    parameter int GATE_LO = 4,
    parameter int GATE_HI = 6
) (
    input  logic              bypass,
    input  logic              byp_ref,
    input  logic              a_div,
    input  logic              b_div,
    input  logic              se_block,
    input  logic              oe,
    output logic [N_DIFF-1:0] q_diff,
    output logic              q_se,
    output logic              grp_hiz
);

    generate
        for (genvar i = 0; i < N_DIFF; i++) begin : g_lane
            logic src;
            if (i == 0) begin : g_bank_a
                assign src = bypass ? byp_ref : a_div;
            end else begin : g_bank_b
                assign src = bypass ? byp_ref : b_div;
            end
            if (i >= GATE_LO && i <= GATE_HI) begin : g_gated
                assign q_diff[i] = oe & src;
            end else begin : g_free
                assign q_diff[i] = src;
            end
        end
    endgenerate

    assign q_se    = bypass ? byp_ref : (b_div & ~se_block);
    assign grp_hiz = ~oe;

endmodule

// File: rtl/clk_fanout_div.sv
`timescale 1ns/1ps
module clk_fanout_div
    import fo_div_pkg::*;
#(
    parameter int N_DIFF  = 7,
    parameter int GATE_LO = 4,
    parameter int GATE_HI = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ref_mode,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic              oe,
    input  logic              byp_ref,
    output logic [N_DIFF-1:0] q_diff,
    output logic              q_se,
    output logic              grp_hiz,
    output logic              se_unsup,
    output logic              xtal_sel,
    output logic              vco_en,
    output logic              fb_tick
);

    ref_src_e src;
    logic     bypass;
    logic     a_div, b_div;
    logic     a_fast, b_fast;

    assign src      = lvl_to_src(ref_mode);
    assign bypass   = (src == SRC_BYPASS);
    assign xtal_sel = (src == SRC_XTAL);
    assign vco_en   = !bypass;

    fo_div_bank #(.FLAG_FAST(1'b0), .FAST_BELOW(SE_MIN_RATIO)) i_bank_a (
        .clk      (clk),
        .rst      (rst),
        .hold     (bypass),
        .sel      (sel_a),
        .div_out  (a_div),
        .too_fast (a_fast)
    );

    fo_div_bank #(.FLAG_FAST(1'b1), .FAST_BELOW(SE_MIN_RATIO)) i_bank_b (
        .clk      (clk),
        .rst      (rst),
        .hold     (bypass),
        .sel      (sel_b),
        .div_out  (b_div),
        .too_fast (b_fast)
    );

    assign se_unsup = vco_en & (a_fast | b_fast);

    fo_fb_div #(.RATIO(FB_RATIO)) i_fb (
        .clk  (clk),
        .rst  (rst),
        .hold (bypass),
        .tick (fb_tick)
    );

    fo_out_stage #(.N_DIFF(N_DIFF), .GATE_LO(GATE_LO), .GATE_HI(GATE_HI)) i_out (
        .bypass   (bypass),
        .byp_ref  (byp_ref),
        .a_div    (a_div),
        .b_div    (b_div),
        .se_block (se_unsup),
        .oe       (oe),
        .q_diff   (q_diff),
        .q_se     (q_se),
        .grp_hiz  (grp_hiz)
    );

endmodule

// File: rtl/fo_div_chk.sv
`timescale 1ns/1ps
module fo_div_chk #(
    parameter int N_DIFF  = 7,
    parameter int GATE_LO = 4,
    parameter int GATE_HI = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ref_mode,
    input logic              oe,
    input logic              byp_ref,
    input logic [N_DIFF-1:0] q_diff,
    input logic              q_se,
    input logic              grp_hiz,
    input logic              se_unsup,
    input logic              xtal_sel,
    input logic              vco_en,
    input logic              fb_tick
);

    p_grp_off_r8: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (grp_hiz && q_diff[GATE_HI:GATE_LO] == '0));

    p_grp_on_r8: assert property (@(posedge clk) disable iff (rst)
        oe |-> !grp_hiz);

    p_se_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        se_unsup |-> !q_se);

    p_bypass_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_mode == 2'b00) |-> (q_diff[0] == byp_ref && q_se == byp_ref && !fb_tick && !vco_en));

    p_fb_single_r10: assert property (@(posedge clk) disable iff (rst)
        fb_tick |=> !fb_tick);

    p_first_low_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && vco_en) |-> (q_diff == '0 && !q_se));

    p_xtal_mode_r6: assert property (@(posedge clk) disable iff (rst)
        xtal_sel |-> (vco_en && ref_mode == 2'b01));

endmodule

bind clk_fanout_div fo_div_chk #(.N_DIFF(N_DIFF), .GATE_LO(GATE_LO), .GATE_HI(GATE_HI)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_mode (ref_mode),
    .oe       (oe),
    .byp_ref  (byp_ref),
    .q_diff   (q_diff),
    .q_se     (q_se),
    .grp_hiz  (grp_hiz),
    .se_unsup (se_unsup),
    .xtal_sel (xtal_sel),
    .vco_en   (vco_en),
    .fb_tick  (fb_tick)
);

// File: tb/test_clk_fanout_div.sv
`timescale 1ns/1ps
module test_clk_fanout_div;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ref_mode, sel_a, sel_b;
    logic       oe, byp_ref;
    logic [6:0] q_diff;
    logic       q_se, grp_hiz, se_unsup, xtal_sel, vco_en, fb_tick;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    model_ok = 0;
    bit    done     = 0;
    string cur_req  = "R5";

    // behavioural reference state
    int cnt_a, n_a, st_a, cnt_b, n_b, st_b, fbc;

    always #2 clk = ~clk;

    clk_fanout_div i_clk_fanout_div (
        .clk(clk), .rst(rst), .ref_mode(ref_mode), .sel_a(sel_a), .sel_b(sel_b),
        .oe(oe), .byp_ref(byp_ref), .q_diff(q_diff), .q_se(q_se), .grp_hiz(grp_hiz),
        .se_unsup(se_unsup), .xtal_sel(xtal_sel), .vco_en(vco_en), .fb_tick(fb_tick)
    );

    function automatic int ratio_of(input logic [1:0] c);
        if (c == 2'b00) return 5;
        if (c == 2'b01) return 4;
        return 2;
    endfunction

    // h counts half-cycles from the start of the output period
    function automatic bit level_of(input int n, input int started, input int h);
        if (started == 0) return 1'b0;
        if (n % 2 == 1) return (h >= 1 && h <= n);
        return (h < n);
    endfunction

    task automatic model_step();
        if (rst || ref_mode == 2'b00) begin
            cnt_a = 0; n_a = ratio_of(sel_a); st_a = 0;
            cnt_b = 0; n_b = ratio_of(sel_b); st_b = 0;
            fbc = 0;
        end else begin
            if (cnt_a == n_a - 1) begin cnt_a = 0; n_a = ratio_of(sel_a); st_a = 1; end
            else cnt_a++;
            if (cnt_b == n_b - 1) begin cnt_b = 0; n_b = ratio_of(sel_b); st_b = 1; end
            else cnt_b++;
            fbc = (fbc == 24) ? 0 : fbc + 1;
        end
    endtask

    task automatic compare(input int second_half);
        bit        byp, vco, unsup, ea, eb, src;
        logic [11:0] exp_v, act_v;
        byp   = (ref_mode == 2'b00);
        vco   = !byp;
        unsup = vco && (n_b < 4);
        ea    = level_of(n_a, st_a, 2 * cnt_a + second_half);
        eb    = level_of(n_b, st_b, 2 * cnt_b + second_half);
        for (int i = 0; i < 7; i++) begin
            src = byp ? byp_ref : ((i == 0) ? ea : eb);
            exp_v[11 - 6 + i] = (i >= 4 && !oe) ? 1'b0 : src;
        end
        exp_v[4] = byp ? byp_ref : (unsup ? 1'b0 : eb);
        exp_v[3] = !oe;
        exp_v[2] = unsup;
        exp_v[1] = (ref_mode == 2'b01);
        exp_v[0] = vco;
        act_v    = {q_diff, q_se, grp_hiz, se_unsup, xtal_sel, vco_en};
        n_checks++;
        if (act_v != exp_v || fb_tick !== (vco && fbc == 24)) begin
            n_fails++;
            $display("FAIL %s t=%0t actual=%b/%b expected=%b/%b", cur_req, $time,
                     act_v, fb_tick, exp_v, (vco && fbc == 24));
        end
    endtask

    always @(posedge clk) begin
        #1;
        model_step();
        model_ok = 1;
        if (!done) compare(0);
    end

    always @(negedge clk) begin
        #1;
        if (model_ok && !done) compare(1);
    end

    task automatic go(input int n);
        repeat (n) @(negedge clk);
        #1.5;
    endtask

    initial begin
        rst = 1'b1; ref_mode = 2'b01; sel_a = 2'b00; sel_b = 2'b01; oe = 1'b1; byp_ref = 1'b0;
        cur_req = "R5"; go(3);
        rst = 1'b0; go(6);
        cur_req = "R2"; go(20);
        cur_req = "R10"; go(30);
        cur_req = "R1"; sel_a = 2'b10; go(12); sel_a = 2'b11; go(8); sel_a = 2'b01; go(10);
        cur_req = "R4"; go(1); sel_a = 2'b00; go(2); sel_a = 2'b01; go(1); sel_b = 2'b00; go(3);
        sel_a = 2'b10; sel_b = 2'b10; go(1); sel_a = 2'b00; go(20);
        cur_req = "R9"; sel_b = 2'b10; go(20); sel_b = 2'b11; go(10);
        cur_req = "R3"; sel_b = 2'b01; sel_a = 2'b00; go(20); sel_a = 2'b10; go(12);
        cur_req = "R8"; oe = 1'b0; go(15); oe = 1'b1; go(6);
        cur_req = "R6"; ref_mode = 2'b10; go(10); ref_mode = 2'b11; go(6);
        cur_req = "R7"; ref_mode = 2'b00;
        for (int k = 0; k < 20; k++) begin
            byp_ref = (k % 3) != 0;
            if (k == 10) oe = 1'b0;
            go(1);
        end
        byp_ref = 1'b0; oe = 1'b1;
        cur_req = "R5"; ref_mode = 2'b01; go(30);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule